// File: doc/BRIEF.md
# Counter Compare Event Unit

This block watches a free-running 32-bit counter that lives outside it. It raises a one-shot event whenever the count reaches a value that software has programmed. Eight independent compare channels each hold a 32-bit target and an enable bit. When the live count becomes equal to an enabled target, the channel sets a sticky pending bit. The registered interrupt output is the OR of all pending bits whose channel is still enabled. The unit drives nothing back into the counter, so a match neither reloads nor stops it.

The intended use is to let one counter act both as the system timebase and as the source of timed events. Software reads the current count, adds the wanted delay with 32-bit wrap-around arithmetic and writes the sum into a compare slot. Because the counter wraps modulo 2^32 on its own, a target that lies past the wrap point matches once the count has wrapped. Pending bits are cleared by writing ones to a clear-on-one status location.

Top module: `cmp_event_unit`

## Requirements
- R1: After a synchronous active-high reset, `pend_o` is all zero, `irq_o` is 0, every channel is disabled and every target is 0.
- R2: A write to byte address 0x60 + 4*i (i = 0..7) loads `wr_data` as the target of channel i. A write to 0x40 loads the enable bits from `wr_data[7:0]`, where bit i enables channel i. A write to 0x44 is the clear-on-one status write. Writes to any other address have no effect. Each write takes effect at the clock edge at which `wr_en` is sampled high.
- R3: Channel i sets `pend_o[i]` at the clock edge that ends a cycle in which all of the following hold: `count_i` equals target i, the same equality did not hold in the previous cycle, and channel i is enabled.
- R4: While `count_i` and the target stay unchanged across several cycles, at most one event is raised.
- R5: A disabled channel never sets its pending bit. Enabling a channel while the count already sits on its target raises no event until the equality is newly reached.
- R6: A pending bit stays set until a status write has a 1 in that bit position. Zero bits in a status write leave pending bits unchanged. If an event and a clear for the same bit occur at the same edge, the bit ends up set.
- R7: `irq_o` is registered. It equals the OR of (pending AND enable) as they stood one cycle earlier. Disabling a channel masks its pending bit from `irq_o` but leaves the bit pending.
- R8: A target computed as count plus delay modulo 2^32 matches after the counter wraps from 0xFFFFFFFF to 0.
- R9: Channels are independent. Several channels with the same target set their pending bits at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 32 | Register write data |
| count_i | input | 32 | Live value of the external free-running counter |
| pend_o | output | 8 | Sticky pending bit per channel |
| irq_o | output | 1 | Compare interrupt, OR of enabled pending bits |

## Verification
The bench targets a count that stalls on a target. A design that fires on the level of the equality, rather than on its first cycle, would set the pending bit again right after software clears it. It enables a channel while the count already equals its target; a design that samples the enable too late or skips the previous-equality state would raise a spurious event there. A clear and an event land on the same bit at the same edge, where a clear-priority design would lose the event. A target that lies beyond the 2^32 wrap must still match once the count has wrapped. Disabling a channel must drop the interrupt while the pending bit stays set.

// File: rtl/cmpev_pkg.sv
package cmpev_pkg;
  localparam int ENA_ADDR  = 'h40;
  localparam int STAT_ADDR = 'h44;
  localparam int CMP_BASE  = 'h60;
  localparam int CMP_STEP  = 4;
endpackage

// File: rtl/cmpev_regs.sv
module cmpev_regs #(
  parameter int NUM_CMP = 8,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [CNT_W-1:0]                wr_data,
  output logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_val,
  output logic [NUM_CMP-1:0]              en_q,
  output logic [NUM_CMP-1:0]              clr_mask
);
  import cmpev_pkg::*;

  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(ENA_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  always_ff @(posedge clk) begin
    if (rst)
      en_q <= '0;
    else if (wr_en && wr_addr == A_ENA)
      en_q <= wr_data[NUM_CMP-1:0];
  end

  assign clr_mask = (wr_en && wr_addr == A_STAT) ? wr_data[NUM_CMP-1:0] : '0;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(CMP_BASE + CMP_STEP * i);
    always_ff @(posedge clk) begin
      if (rst)
        cmp_val[i] <= '0;
      else if (wr_en && wr_addr == A_CMP)
        cmp_val[i] <= wr_data;
    end
  end
endmodule

// File: rtl/cmpev_slot.sv
module cmpev_slot #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             en_i,
  output logic             evt_o
);
  logic eq;
  logic eq_q;

  assign eq = (count_i == cmp_i);

  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b0;
    else     eq_q <= eq;
  end

  assign evt_o = eq && !eq_q && en_i;

  // R4: an unchanged count and target cannot produce a fresh event
  p_held_once_r4: assert property (@(posedge clk) disable iff (rst)
    ($stable(count_i) && $stable(cmp_i)) |-> !evt_o);
endmodule

// File: rtl/cmp_event_unit.sv
module cmp_event_unit #(
  parameter int NUM_CMP = 8,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [CNT_W-1:0]   count_i,
  output logic [NUM_CMP-1:0] pend_o,
  output logic               irq_o
);
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val;
  logic [NUM_CMP-1:0]            en_q;
  logic [NUM_CMP-1:0]            clr_mask;
  logic [NUM_CMP-1:0]            evt_vec;
  logic [NUM_CMP-1:0]            pend_q;
  logic                          irq_q;

  cmpev_regs #(.NUM_CMP(NUM_CMP), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_val(cmp_val), .en_q(en_q), .clr_mask(clr_mask)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
    cmpev_slot #(.CNT_W(CNT_W)) slot_i (
      .clk(clk), .rst(rst), .count_i(count_i), .cmp_i(cmp_val[i]),
      .en_i(en_q[i]), .evt_o(evt_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | evt_vec;
      irq_q  <= |(pend_q & en_q);
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  // R5: a bit can only become pending if its channel was enabled
  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (pend_q & ~$past(pend_q) & ~$past(en_q)) == '0);

  // R6: pending bits persist unless cleared by a status write
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (($past(pend_q) & ~$past(clr_mask)) & ~pend_q) == '0);

  // R7: the interrupt only rises when something was pending
  p_irq_src_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(|pend_q));
endmodule

// File: tb/cmp_event_unit_tb.sv
module cmp_event_unit_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] count_i = '0;
  logic [7:0]  pend_o;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  cmp_event_unit dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_i(count_i), .pend_o(pend_o), .irq_o(irq_o)
  );

  // behavioural reference model
  logic [31:0] mcmp [8];
  logic [7:0]  men, mpend, meqp, m_eq, m_evt, m_clr;
  logic        mirq;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) mcmp[i] = '0;
      men = '0; mpend = '0; meqp = '0; mirq = 1'b0;
    end else begin
      for (int i = 0; i < 8; i++) m_eq[i] = (count_i == mcmp[i]);
      m_evt = m_eq & ~meqp & men;
      m_clr = (wr_en && wr_addr == 8'h44) ? wr_data[7:0] : 8'h00;
      mirq  = |(mpend & men);
      mpend = (mpend & ~m_clr) | m_evt;
      meqp  = m_eq;
      if (wr_en) begin
        if (wr_addr == 8'h40) men = wr_data[7:0];
        for (int i = 0; i < 8; i++)
          if (wr_addr == 8'(8'h60 + 4*i)) mcmp[i] = wr_data;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (pend_o !== mpend) begin
        errors++;
        $display("FAIL R3 model pend_o actual=%h expected=%h t=%0t", pend_o, mpend, $time);
      end
      checks++;
      if (irq_o !== mirq) begin
        errors++;
        $display("FAIL R7 model irq_o actual=%b expected=%b t=%0t", irq_o, mirq, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                     input logic [31:0] c);
    wr_en = we; wr_addr = a; wr_data = d; count_i = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] tgt;
    @(negedge clk);
    repeat (3) cyc(0, 0, 0, 0);
    rst = 1'b0;
    cyc(0, 0, 0, 5);
    chk("R1 reset pend", 32'(pend_o), 0);
    chk("R1 reset irq", 32'(irq_o), 0);

    // R3 basic match on channel 0, R2 address 0x60
    cyc(1, 8'h60, 100, 90);
    cyc(1, 8'h40, 1, 91);
    for (int c = 92; c < 100; c++) cyc(0, 0, 0, c);
    chk("R3 no early event", 32'(pend_o), 0);
    cyc(0, 0, 0, 100);
    chk("R3 match sets pend0", 32'(pend_o), 1);
    cyc(0, 0, 0, 101);
    chk("R7 irq follows pend", 32'(irq_o), 1);
    cyc(1, 8'h44, 0, 102);
    chk("R6 zero clear bits keep pend", 32'(pend_o), 1);
    cyc(1, 8'h44, 1, 103);
    chk("R6 clear pend0", 32'(pend_o), 0);

    // R4 held count
    cyc(1, 8'h64, 200, 150);
    cyc(1, 8'h40, 3, 151);
    cyc(0, 0, 0, 200);
    chk("R4 first hit", 32'(pend_o), 2);
    cyc(1, 8'h44, 2, 200);
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 200);
    chk("R4 no repeat while held", 32'(pend_o), 0);

    // R5 disabled channel
    cyc(1, 8'h68, 300, 250);
    cyc(0, 0, 0, 299);
    cyc(0, 0, 0, 300);
    cyc(0, 0, 0, 301);
    chk("R5 disabled no pend", 32'(pend_o), 0);
    cyc(0, 0, 0, 300);
    cyc(1, 8'h40, 7, 300);
    cyc(0, 0, 0, 300);
    chk("R5 enable while equal no event", 32'(pend_o), 0);
    cyc(0, 0, 0, 301);
    cyc(0, 0, 0, 300);
    chk("R3 new equality after enable", 32'(pend_o), 4);
    cyc(1, 8'h44, 8'hFF, 301);

    // R6 set wins over clear
    cyc(0, 0, 0, 299);
    cyc(1, 8'h44, 4, 300);
    chk("R6 set beats clear", 32'(pend_o), 4);
    cyc(1, 8'h44, 4, 301);
    chk("R6 cleared", 32'(pend_o), 0);

    // R7 masking
    cyc(0, 0, 0, 299);
    cyc(0, 0, 0, 300);
    cyc(0, 0, 0, 301);
    chk("R7 irq on", 32'(irq_o), 1);
    cyc(1, 8'h40, 3, 302);
    cyc(0, 0, 0, 303);
    chk("R7 irq masked", 32'(irq_o), 0);
    chk("R7 pend kept", 32'(pend_o), 4);
    cyc(1, 8'h44, 8'hFF, 304);

    // R8 wrap-around target
    tgt = 32'hFFFF_FFF0 + 32'h20;
    cyc(1, 8'h6C, tgt, 32'hFFFF_FFF0);
    cyc(1, 8'h40, 8'h0B, 32'hFFFF_FFF1);
    for (int k = 0; k < 30; k++) cyc(0, 0, 0, 32'hFFFF_FFF2 + 32'(k));
    chk("R8 no event before target", 32'(pend_o), 0);
    cyc(0, 0, 0, tgt);
    chk("R8 match after wrap", 32'(pend_o), 8);
    cyc(1, 8'h44, 8'hFF, 32'h11);

    // R9 two channels same target
    cyc(1, 8'h70, 500, 480);
    cyc(1, 8'h74, 500, 481);
    cyc(1, 8'h40, 8'h30, 482);
    cyc(0, 0, 0, 499);
    cyc(0, 0, 0, 500);
    chk("R9 both pend together", 32'(pend_o), 32'h30);
    cyc(1, 8'h44, 8'hFF, 501);

    // R2 decode: stray addresses ignored, last slot at 0x7C
    cyc(1, 8'h7C, 700, 630);
    cyc(1, 8'h80, 650, 631);
    cyc(1, 8'h5C, 650, 632);
    cyc(1, 8'h40, 8'hFF, 633);
    for (int c = 640; c <= 660; c++) cyc(0, 0, 0, c);
    chk("R2 stray writes ignored", 32'(pend_o), 0);
    cyc(0, 0, 0, 699);
    cyc(0, 0, 0, 700);
    chk("R2 last slot address", 32'(pend_o), 32'h80);
    cyc(0, 0, 0, 701);

    finish_run();
  end
endmodule